// File: doc/BRIEF.md
# Video raster sync timing generator

This block is the free-running timing source of a composite video encoder operating as the sync master. It counts pixel clocks along each line and lines down each field, and from those two counts it derives a horizontal sync pulse, a vertical sync pulse, an active-video line window, an odd/even field flag and a flag that marks the first field of the colour sequence. The current pixel and line numbers are also brought out so that downstream insertion logic can key on them.

Three standards are selectable. One is a 60 Hz standard with a 4-field colour sequence. Two are 50 Hz standards, one with an 8-field sequence and one with a 12-field sequence. In interlaced scan, fields alternate between a long field and a short field. In progressive scan, every field has the short length and no parity information is produced. All lengths are parameters. The defaults are 1728 or 1716 clocks per line, 313/312 or 263/262 lines per field, 128 sync clocks and 3 sync lines.

Top module: `raster_timing_gen`

## Requirements
- R1: `pix_cnt` counts 0, 1, ... up to line length minus one and then returns to 0. The line length is LINE_CLKS_60 when the held standard code is 2'b00 and LINE_CLKS_50 for every other code (2'b01, 2'b10, 2'b11).
- R2: `hsync` is high exactly while `pix_cnt` is below HSYNC_CLKS.
- R3: `vsync` is high exactly while `line_cnt` is between 1 and VSYNC_LINES.
- R4: `line_cnt` runs from 1 to the field length and advances only when a line wraps. The base field length is FIELD_LINES_60 for code 2'b00 and FIELD_LINES_50 otherwise. In interlaced scan, fields with an even sequence index are one line longer than the base. In progressive scan, every field has the base length.
- R5: `even_field` is 1 during fields with an odd sequence index and 0 during fields with an even index in interlaced scan. It is always 0 in progressive scan.
- R6: The sequence index steps by one at each field end and returns to 0 when it reaches 4 (code 2'b00), 12 (code 2'b10) or 8 (codes 2'b01 and 2'b11), using the newly taken code. `seq_first` is high for the whole field whose index is 0.
- R7: `active_video` is high exactly when `first_active` <= `line_cnt` <= `last_active`.
- R8: `std_sel` and `progressive` are taken only on the last clock of a field and during reset. A change at any other time has no effect on line length, field length or parity until the next field starts.
- R9: A synchronous reset places the generator at pixel 0, line 1, sequence index 0, and takes the current `std_sel` and `progressive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| std_sel | input | 2 | Standard code: 00 = 60 Hz/4-field, 01 = 50 Hz/8-field, 10 = 50 Hz/12-field, 11 = as 01 |
| progressive | input | 1 | 1 selects non-interlaced scan |
| first_active | input | LINE_W | First line of the active window |
| last_active | input | LINE_W | Last line of the active window |
| hsync | output | 1 | Horizontal sync pulse |
| vsync | output | 1 | Vertical sync pulse |
| even_field | output | 1 | Field parity flag |
| seq_first | output | 1 | First field of the colour sequence |
| active_video | output | 1 | Active line window |
| pix_cnt | output | PIX_W | Pixel position within the line |
| line_cnt | output | LINE_W | Line number within the field, starting at 1 |

## Verification
With the default OUT_REG = 0, every output is a function of the counter state. It therefore reflects a clock edge immediately after that edge. `active_video` also follows `first_active` and `last_active` with no clock delay. A `std_sel` or `progressive` change shows up only in the field after the next field-end edge. The bench drives inputs one time unit after the rising edge and keeps a model state that advances on the same rising edge. It then compares every output against that state at the falling edge, so each result is sampled half a period after the edge that produced it. Reduced line and field lengths let full 12-field sequences, mid-field standard changes and reset in mid-field all occur within the run.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

   typedef enum logic [1:0] {
      STD_60_4F  = 2'b00,
      STD_50_8F  = 2'b01,
      STD_50_12F = 2'b10,
      STD_50_ALT = 2'b11
   } rtg_std_e;

   function automatic logic is_60hz(rtg_std_e s);
      return (s == STD_60_4F);
   endfunction

   function automatic logic [3:0] seq_fields(rtg_std_e s);
      case (s)
         STD_60_4F:  return 4'd4;
         STD_50_12F: return 4'd12;
         default:    return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/rtg_pix_ctr.sv
module rtg_pix_ctr #(
   parameter int PIX_W        = 11,
   parameter int LINE_CLKS_50 = 1728,
   parameter int LINE_CLKS_60 = 1716
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             is60,
   output logic [PIX_W-1:0] pix_o,
   output logic             line_end_o
);
   localparam logic [PIX_W-1:0] LAST50 = PIX_W'(LINE_CLKS_50 - 1);
   localparam logic [PIX_W-1:0] LAST60 = PIX_W'(LINE_CLKS_60 - 1);

   logic [PIX_W-1:0] pix_q;
   logic [PIX_W-1:0] last_pix;

   assign last_pix   = is60 ? LAST60 : LAST50;
   assign line_end_o = (pix_q == last_pix);
   assign pix_o      = pix_q;

   always_ff @(posedge clk) begin
      if (rst)             pix_q <= '0;
      else if (line_end_o) pix_q <= '0;
      else                 pix_q <= pix_q + PIX_W'(1);
   end

   // R1
   pix_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      line_end_o |=> (pix_q == '0));

   // R1
   pix_step_chk: assert property (@(posedge clk) disable iff (rst)
      !line_end_o |=> (pix_q == $past(pix_q) + PIX_W'(1)));

endmodule

// File: rtl/rtg_line_ctr.sv
module rtg_line_ctr #(
   parameter int LINE_W         = 9,
   parameter int FIELD_LINES_50 = 312,
   parameter int FIELD_LINES_60 = 262
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              line_end,
   input  logic              is60,
   input  logic              long_field,
   output logic [LINE_W-1:0] line_o,
   output logic              field_end_o
);
   localparam logic [LINE_W-1:0] BASE50 = LINE_W'(FIELD_LINES_50);
   localparam logic [LINE_W-1:0] BASE60 = LINE_W'(FIELD_LINES_60);

   logic [LINE_W-1:0] line_q;
   logic [LINE_W-1:0] last_line;

   assign last_line   = (is60 ? BASE60 : BASE50) + {{(LINE_W-1){1'b0}}, long_field};
   assign field_end_o = line_end && (line_q == last_line);
   assign line_o      = line_q;

   always_ff @(posedge clk) begin
      if (rst)              line_q <= LINE_W'(1);
      else if (field_end_o) line_q <= LINE_W'(1);
      else if (line_end)    line_q <= line_q + LINE_W'(1);
   end

   // R4
   line_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !line_end |=> $stable(line_q));

   // R4
   line_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
      line_q != '0);

endmodule

// File: rtl/rtg_field_seq.sv
module rtg_field_seq
   import rtg_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       field_end,
   input  rtg_std_e   std_in,
   input  logic       prog_in,
   output rtg_std_e   std_o,
   output logic       prog_o,
   output logic [3:0] idx_o
);
   rtg_std_e   std_q;
   logic       prog_q;
   logic [3:0] idx_q;
   logic [3:0] idx_inc;

   assign idx_inc = idx_q + 4'd1;
   assign std_o   = std_q;
   assign prog_o  = prog_q;
   assign idx_o   = idx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         std_q  <= std_in;
         prog_q <= prog_in;
         idx_q  <= 4'd0;
      end else if (field_end) begin
         std_q  <= std_in;
         prog_q <= prog_in;
         idx_q  <= (idx_inc >= seq_fields(std_in)) ? 4'd0 : idx_inc;
      end
   end

   // R8
   std_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !field_end |=> ($stable(std_q) && $stable(prog_q)));

   // R6
   idx_range_chk: assert property (@(posedge clk) disable iff (rst)
      idx_q < seq_fields(std_q));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int LINE_CLKS_50   = 1728,
   parameter int LINE_CLKS_60   = 1716,
   parameter int FIELD_LINES_50 = 312,
   parameter int FIELD_LINES_60 = 262,
   parameter int HSYNC_CLKS     = 128,
   parameter int VSYNC_LINES    = 3,
   parameter int PIX_W          = 11,
   parameter int LINE_W         = 9,
   parameter bit OUT_REG        = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        std_sel,
   input  logic              progressive,
   input  logic [LINE_W-1:0] first_active,
   input  logic [LINE_W-1:0] last_active,
   output logic              hsync,
   output logic              vsync,
   output logic              even_field,
   output logic              seq_first,
   output logic              active_video,
   output logic [PIX_W-1:0]  pix_cnt,
   output logic [LINE_W-1:0] line_cnt
);
   localparam int MAX_LINE_CLKS = (LINE_CLKS_50 > LINE_CLKS_60) ? LINE_CLKS_50 : LINE_CLKS_60;
   localparam int MAX_FIELD     = ((FIELD_LINES_50 > FIELD_LINES_60) ? FIELD_LINES_50 : FIELD_LINES_60) + 1;
   localparam int MIN_FIELD     = (FIELD_LINES_50 < FIELD_LINES_60) ? FIELD_LINES_50 : FIELD_LINES_60;
   localparam int MIN_LINE_CLKS = (LINE_CLKS_50 < LINE_CLKS_60) ? LINE_CLKS_50 : LINE_CLKS_60;

   if (MAX_LINE_CLKS > (1 << PIX_W)) begin : g_pix_w_bad
      $error("PIX_W too narrow for the line length");
   end
   if (MAX_FIELD >= (1 << LINE_W)) begin : g_line_w_bad
      $error("LINE_W too narrow for the field length");
   end
   if (HSYNC_CLKS < 1 || HSYNC_CLKS >= MIN_LINE_CLKS) begin : g_hs_bad
      $error("HSYNC_CLKS must lie inside a line");
   end
   if (VSYNC_LINES < 1 || VSYNC_LINES >= MIN_FIELD) begin : g_vs_bad
      $error("VSYNC_LINES must lie inside a field");
   end

   rtg_std_e          std_q;
   logic              prog_q;
   logic [3:0]        idx_q;
   logic              is60;
   logic              line_end;
   logic              field_end;
   logic              long_field;
   logic [PIX_W-1:0]  pix_q;
   logic [LINE_W-1:0] line_q;

   assign is60       = is_60hz(std_q);
   assign long_field = !prog_q && !idx_q[0];

   rtg_pix_ctr #(
      .PIX_W(PIX_W), .LINE_CLKS_50(LINE_CLKS_50), .LINE_CLKS_60(LINE_CLKS_60)
   ) u_pix (
      .clk(clk), .rst(rst), .is60(is60), .pix_o(pix_q), .line_end_o(line_end)
   );

   rtg_line_ctr #(
      .LINE_W(LINE_W), .FIELD_LINES_50(FIELD_LINES_50), .FIELD_LINES_60(FIELD_LINES_60)
   ) u_line (
      .clk(clk), .rst(rst), .line_end(line_end), .is60(is60),
      .long_field(long_field), .line_o(line_q), .field_end_o(field_end)
   );

   rtg_field_seq u_seq (
      .clk(clk), .rst(rst), .field_end(field_end),
      .std_in(rtg_std_e'(std_sel)), .prog_in(progressive),
      .std_o(std_q), .prog_o(prog_q), .idx_o(idx_q)
   );

   logic hs_c, vs_c, ev_c, sf_c, av_c;

   assign hs_c = (pix_q < PIX_W'(HSYNC_CLKS));
   assign vs_c = (line_q <= LINE_W'(VSYNC_LINES));
   assign ev_c = !prog_q && idx_q[0];
   assign sf_c = (idx_q == 4'd0);
   assign av_c = (line_q >= first_active) && (line_q <= last_active);

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            hsync        <= 1'b0;
            vsync        <= 1'b0;
            even_field   <= 1'b0;
            seq_first    <= 1'b0;
            active_video <= 1'b0;
            pix_cnt      <= '0;
            line_cnt     <= '0;
         end else begin
            hsync        <= hs_c;
            vsync        <= vs_c;
            even_field   <= ev_c;
            seq_first    <= sf_c;
            active_video <= av_c;
            pix_cnt      <= pix_q;
            line_cnt     <= line_q;
         end
      end
   end else begin : g_out_comb
      assign hsync        = hs_c;
      assign vsync        = vs_c;
      assign even_field   = ev_c;
      assign seq_first    = sf_c;
      assign active_video = av_c;
      assign pix_cnt      = pix_q;
      assign line_cnt     = line_q;
   end

   // R2
   hsync_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(hs_c) |-> (pix_q == '0));

   // R6
   seq_start_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sf_c) |-> (line_q == LINE_W'(1) && pix_q == '0));

   // R5
   parity_start_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ev_c) |-> (line_q == LINE_W'(1) && pix_q == '0));

   // R3
   vsync_start_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(vs_c) |-> (line_q == LINE_W'(1)));

endmodule

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
   localparam int CLK_PERIOD = 10;
   localparam int LC50 = 24;
   localparam int LC60 = 20;
   localparam int FL50 = 12;
   localparam int FL60 = 10;
   localparam int HS   = 4;
   localparam int VS   = 2;
   localparam int PW   = 5;
   localparam int LW   = 9;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    std_sel = 2'b01;
   logic          progressive = 1'b0;
   logic [LW-1:0] first_active = 9'd3;
   logic [LW-1:0] last_active  = 9'd8;
   logic          hsync, vsync, even_field, seq_first, active_video;
   logic [PW-1:0] pix_cnt;
   logic [LW-1:0] line_cnt;

   int n_tests = 0;
   int n_fail  = 0;
   bit cmp_on  = 1'b0;
   bit done    = 1'b0;

   int mpix, mline, mf, mstd;
   bit mprog;

   always #(CLK_PERIOD/2) clk = ~clk;

   raster_timing_gen #(
      .LINE_CLKS_50(LC50), .LINE_CLKS_60(LC60),
      .FIELD_LINES_50(FL50), .FIELD_LINES_60(FL60),
      .HSYNC_CLKS(HS), .VSYNC_LINES(VS),
      .PIX_W(PW), .LINE_W(LW), .OUT_REG(1'b0)
   ) dut (
      .clk(clk), .rst(rst), .std_sel(std_sel), .progressive(progressive),
      .first_active(first_active), .last_active(last_active),
      .hsync(hsync), .vsync(vsync), .even_field(even_field),
      .seq_first(seq_first), .active_video(active_video),
      .pix_cnt(pix_cnt), .line_cnt(line_cnt)
   );

   function automatic int seq_len(int s);
      return (s == 0) ? 4 : (s == 2) ? 12 : 8;
   endfunction
   function automatic int line_len(int s);
      return (s == 0) ? LC60 : LC50;
   endfunction
   function automatic int field_len(int s, bit p, int f);
      return ((s == 0) ? FL60 : FL50) + ((!p && (f % 2 == 0)) ? 1 : 0);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // reference state, advanced on the same edge as the design
   always @(posedge clk) begin
      if (rst) begin
         mpix = 0; mline = 1; mf = 0;
         mstd = int'(std_sel); mprog = progressive;
      end else if (mpix == line_len(mstd) - 1) begin
         mpix = 0;
         if (mline == field_len(mstd, mprog, mf)) begin
            mline = 1;
            mstd  = int'(std_sel);
            mprog = progressive;
            mf    = (mf + 1 >= seq_len(mstd)) ? 0 : mf + 1;
         end else begin
            mline++;
         end
      end else begin
         mpix++;
      end
   end

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         check(int'(pix_cnt) == mpix, "R1 R8 pix_cnt", int'(pix_cnt), mpix);
         check(int'(line_cnt) == mline, "R4 R8 line_cnt", int'(line_cnt), mline);
         check(hsync == (mpix < HS), "R2 hsync", int'(hsync), int'(mpix < HS));
         check(vsync == (mline <= VS), "R3 vsync", int'(vsync), int'(mline <= VS));
         check(even_field == (!mprog && mf % 2 == 1), "R5 even_field",
               int'(even_field), int'(!mprog && mf % 2 == 1));
         check(seq_first == (mf == 0), "R6 seq_first", int'(seq_first), int'(mf == 0));
         check(active_video == (mline >= int'(first_active) && mline <= int'(last_active)),
               "R7 active_video", int'(active_video),
               int'(mline >= int'(first_active) && mline <= int'(last_active)));
      end
   end

   task automatic run(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic reset_check();
      rst = 1'b1;
      run(2);
      @(negedge clk);
      // R9 reset state
      check(pix_cnt == '0, "R9 reset pix", int'(pix_cnt), 0);
      check(line_cnt == 9'd1, "R9 reset line", int'(line_cnt), 1);
      check(seq_first == 1'b1, "R9 reset seq_first", int'(seq_first), 1);
      check(even_field == 1'b0, "R9 reset even_field", int'(even_field), 0);
      @(posedge clk); #1;
      rst = 1'b0;
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd1234);
      #1;
      reset_check();
      cmp_on = 1'b1;
      // 8-field interlaced sequence, twice
      run(2 * 8 * 13 * LC50);
      // R8: mid-field switch to 60 Hz, effective next field only
      run(37);
      std_sel = 2'b00;
      run(4 * 12 * LC50);
      // R4 R5: progressive scan
      progressive = 1'b1;
      run(6 * 11 * LC60);
      // R6: 12-field sequence
      progressive = 1'b0;
      std_sel = 2'b10;
      run(26 * 13 * LC50);
      // R7 boundaries: single-line window, empty window, full window
      first_active = 9'd1;  last_active = 9'd1;  run(2 * 13 * LC50);
      first_active = 9'd9;  last_active = 9'd4;  run(13 * LC50);
      first_active = 9'd1;  last_active = 9'd13; run(13 * LC50);
      // R9: reset in mid-field
      run(55);
      std_sel = 2'b11;
      cmp_on = 1'b0;
      reset_check();
      cmp_on = 1'b1;
      // constrained random segments
      for (int i = 0; i < 24; i++) begin
         std_sel      = 2'($urandom_range(0, 3));
         progressive  = 1'($urandom_range(0, 1));
         first_active = 9'($urandom_range(0, 14));
         last_active  = 9'($urandom_range(0, 14));
         run($urandom_range(30, 900));
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule